// File: doc/BRIEF.md
# PWM Generator with Synchronized Updates

The block is one PWM time base. A single counter, bounded by a period value, runs in one of two shapes: a sawtooth that counts down from the period value to zero and reloads, or a triangle that climbs from zero to the period value and falls back to zero. Two compare values are tested against the counter. Each raw PWM output goes high after a zero and goes low after its compare value matches on a falling slope. The block flags zero, period and compare events as single-cycle pulses. Two separately selected subsets of these events drive an interrupt line and an ADC trigger line.

The period value and both compare values are double-buffered. A write lands in a pending copy. The pending copy moves into the working copy only on entry to counter zero, so a pulse is never cut short or stretched mid-period. In immediate mode, the next zero applies any pending value. In synchronized mode, the chip-wide update strobe must first arm the block, and the zero after that applies the values. Many generators can then change their values on the same period boundary. A chip-wide restart strobe forces the counter to zero, so that generators with equal period values count in lockstep. A stall input can stop the counter at zero or be ignored, as a configuration input selects.

Top module: `pwm_gen`

## Requirements
- R1: After the asynchronous reset is released, the counter rests at zero, all working and pending values are zero, both PWM outputs are low, and no event, interrupt or trigger is asserted before the first counter step.
- R2: With `updown_i`=0, the counter takes the values P, P-1, ... 0, then reloads P, where P is the working period value. `zero_o` pulses once every P+1 cycles.
- R3: With `updown_i`=1, the counter steps 0, 1, ... P, P-1, ... 1, 0. The zero period is 2P cycles, and `load_o` pulses once at the peak.
- R4: With `sync_upd_i`=0, a written value is pending until the counter next enters zero. It is working from that zero cycle on.
- R5: With `sync_upd_i`=1, pending values are held until `glb_update_i` is seen one or more cycles after the write. They are applied at the next entry to zero after that. A later write before the apply replaces the pending value.
- R6: `glb_reset_i` puts the counter at zero on the next cycle, with a zero event, regardless of stall. The counter then counts from zero as if zero had just been reached.
- R7: `cmpa_o` and `cmpb_o` pulse for one cycle each time the counter takes a value equal to the compare value. In triangle mode this happens on both the rising and falling slopes.
- R8: A PWM output rises the cycle after a zero event. It falls the cycle after its compare event on a falling slope, and the fall wins when both events occur together. In sawtooth mode every slope counts as falling. In triangle mode the peak counts as rising.
- R9: With `stall_run_i`=0 and `stall_i`=1, the counter runs on until it reaches zero and then holds at zero. While it holds, no event pulses are repeated.
- R10: With `stall_run_i`=1, `stall_i` has no effect on counting.
- R11: The event bit order is zero=0, period=1, compare A=2, compare B=3. `irq_o` is the OR of the events enabled in `irq_sel_i`, and `adc_trig_o` is the OR of the events enabled in `trig_sel_i`.
- R12: `wr_sel_i` selects the target of a write: 0 is the period value, 1 is compare A, 2 is compare B. Code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| updown_i | input | 1 | 0: sawtooth down-count, 1: triangle up/down count |
| sync_upd_i | input | 1 | 0: immediate update, 1: update armed by glb_update_i |
| stall_run_i | input | 1 | 1: keep counting during stall, 0: stop at zero |
| irq_sel_i | input | 4 | Events enabled onto irq_o |
| trig_sel_i | input | 4 | Events enabled onto adc_trig_o |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | CNT_W | Write data |
| glb_update_i | input | 1 | Chip-wide update strobe |
| glb_reset_i | input | 1 | Chip-wide counter restart strobe |
| stall_i | input | 1 | Stall request |
| pwm_a_o | output | 1 | Raw PWM output A |
| pwm_b_o | output | 1 | Raw PWM output B |
| zero_o | output | 1 | Counter-at-zero event pulse |
| load_o | output | 1 | Counter-at-period event pulse |
| cmpa_o | output | 1 | Compare A match pulse |
| cmpb_o | output | 1 | Compare B match pulse |
| irq_o | output | 1 | Interrupt from selected events |
| adc_trig_o | output | 1 | ADC trigger from selected events |

## Verification
The hardest cases involve the update path in synchronized mode: a write arriving in the same cycle as an apply, an update strobe landing on the zero entry itself, and a rewrite that replaces an armed value. Each is reachable only by a chance alignment of three independent strobes with the counter phase. The directed part arms updates at known phases and measures the periods that follow. The random part uses short periods (at most 11), frequent writes and update strobes, and occasional restarts and stall toggles, so that these coincidences occur many times and are compared against a cycle model kept in the bench.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_CMPA   = 2'd1,
    SEL_CMPB   = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

  localparam int EV_ZERO = 0;
  localparam int EV_PER  = 1;
  localparam int EV_CMPA = 2;
  localparam int EV_CMPB = 3;
  localparam int EV_N    = 4;
  localparam int NUM_REG = 3;
  localparam int NUM_CMP = 2;
endpackage

// File: rtl/pwm_gen_shadow.sv
module pwm_gen_shadow #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         apply_i,
  output logic [W-1:0] act_o,
  output logic         pend_o
);
  logic [W-1:0] pend_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_val_q <= '0;
      pend_o     <= 1'b0;
      act_o      <= '0;
    end else begin
      // apply moves the old pending copy; a same-cycle write stays pending
      if (apply_i && pend_o) act_o <= pend_val_q;
      if (wr_i) begin
        pend_val_q <= data_i;
        pend_o     <= 1'b1;
      end else if (apply_i) begin
        pend_o     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_gen_cnt.sv
module pwm_gen_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         updown_i,
  input  logic         stall_i,
  input  logic         stall_run_i,
  input  logic         glb_reset_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         fresh_o,
  output logic         zero_enter_o
);
  logic         dir_q;
  logic         adv;
  logic [W-1:0] cnt_nxt;
  logic         dir_nxt;

  assign adv = ~stall_i | stall_run_i | (cnt_o != '0);

  always_comb begin
    if (!updown_i) begin
      cnt_nxt = (cnt_o == '0) ? period_i : cnt_o - 1'b1;
      dir_nxt = 1'b1;
    end else if (cnt_o == '0) begin
      cnt_nxt = (period_i == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
      dir_nxt = 1'b0;
    end else if (!dir_q && cnt_o < period_i) begin
      cnt_nxt = cnt_o + 1'b1;
      dir_nxt = 1'b0;
    end else begin
      cnt_nxt = cnt_o - 1'b1;
      dir_nxt = 1'b1;
    end
  end

  assign zero_enter_o = glb_reset_i | (adv & (cnt_nxt == '0));
  assign down_o       = ~updown_i | dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      dir_q   <= 1'b1;
      fresh_o <= 1'b0;
    end else if (glb_reset_i) begin
      cnt_o   <= '0;
      dir_q   <= 1'b1;
      fresh_o <= 1'b1;
    end else if (adv) begin
      cnt_o   <= cnt_nxt;
      dir_q   <= dir_nxt;
      fresh_o <= 1'b1;
    end else begin
      fresh_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_gen_cmp.sv
module pwm_gen_cmp #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         fresh_i,
  input  logic         down_i,
  input  logic         zero_ev_i,
  output logic         match_o,
  output logic         pwm_o
);
  assign match_o = fresh_i & (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pwm_o <= 1'b0;
    else if (match_o && down_i)  pwm_o <= 1'b0;
    else if (zero_ev_i)          pwm_o <= 1'b1;
  end
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             updown_i,
  input  logic             sync_upd_i,
  input  logic             stall_run_i,
  input  logic [EV_N-1:0]  irq_sel_i,
  input  logic [EV_N-1:0]  trig_sel_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             glb_update_i,
  input  logic             glb_reset_i,
  input  logic             stall_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic             zero_o,
  output logic             load_o,
  output logic             cmpa_o,
  output logic             cmpb_o,
  output logic             irq_o,
  output logic             adc_trig_o
);
  logic [CNT_W-1:0]   act [NUM_REG];
  logic [NUM_REG-1:0] pend;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   load_act;
  logic               down, fresh, zero_enter, apply, armed_q;
  logic [NUM_CMP-1:0] match, pwm;
  logic [EV_N-1:0]    ev;

  assign apply    = zero_enter & (~sync_upd_i | armed_q);
  assign load_act = act[SEL_PERIOD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      armed_q <= 1'b0;
    else if (apply)                   armed_q <= 1'b0;
    else if (glb_update_i && |pend)   armed_q <= 1'b1;
  end

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    pwm_gen_shadow #(.W(CNT_W)) u_shadow (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (wr_sel_i == 2'(k))),
      .data_i  (wr_data_i),
      .apply_i (apply),
      .act_o   (act[k]),
      .pend_o  (pend[k])
    );
  end

  pwm_gen_cnt #(.W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .updown_i     (updown_i),
    .stall_i      (stall_i),
    .stall_run_i  (stall_run_i),
    .glb_reset_i  (glb_reset_i),
    .period_i     (load_act),
    .cnt_o        (cnt),
    .down_o       (down),
    .fresh_o      (fresh),
    .zero_enter_o (zero_enter)
  );

  assign ev[EV_ZERO] = fresh & (cnt == '0);
  assign ev[EV_PER]  = fresh & (cnt == load_act);

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    pwm_gen_cmp #(.W(CNT_W)) u_cmp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (cnt),
      .cmp_i     (act[SEL_CMPA + c]),
      .fresh_i   (fresh),
      .down_i    (down),
      .zero_ev_i (ev[EV_ZERO]),
      .match_o   (match[c]),
      .pwm_o     (pwm[c])
    );
    assign ev[EV_CMPA + c] = match[c];
  end

  assign zero_o     = ev[EV_ZERO];
  assign load_o     = ev[EV_PER];
  assign cmpa_o     = ev[EV_CMPA];
  assign cmpb_o     = ev[EV_CMPB];
  assign pwm_a_o    = pwm[0];
  assign pwm_b_o    = pwm[1];
  assign irq_o      = |(ev & irq_sel_i);
  assign adc_trig_o = |(ev & trig_sel_i);
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         glb_reset_i,
  input logic         stall_i,
  input logic         stall_run_i,
  input logic         sync_upd_i,
  input logic         zero_o,
  input logic         cmpa_o,
  input logic         pwm_a_o,
  input logic         armed_q,
  input logic [W-1:0] load_q,
  input logic [W-1:0] cnt_q
);
  p_zero_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && load_q != '0 && !glb_reset_i) |=> !zero_o);

  p_sync_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_upd_i && !armed_q) |=> $stable(load_q));

  p_restart_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_reset_i |=> zero_o);

  p_pwm_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_a_o) |-> $past(zero_o));

  p_pwm_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_a_o) |-> $past(cmpa_o));

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !stall_run_i && cnt_q == '0 && !glb_reset_i) |=> ($stable(cnt_q) && !zero_o));
endmodule

bind pwm_gen pwm_gen_chk #(.W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .glb_reset_i (glb_reset_i),
  .stall_i     (stall_i),
  .stall_run_i (stall_run_i),
  .sync_upd_i  (sync_upd_i),
  .zero_o      (zero_o),
  .cmpa_o      (cmpa_o),
  .pwm_a_o     (pwm_a_o),
  .armed_q     (armed_q),
  .load_q      (load_act),
  .cnt_q       (cnt)
);

// File: tb/test_pwm_gen.sv
module test_pwm_gen;
  import pwm_gen_pkg::*;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic         updown = 1'b0, sync_upd = 1'b0, stall_run = 1'b0;
  logic [3:0]   irq_sel = '0, trig_sel = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         gupd = 1'b0, greset = 1'b0, stall = 1'b0;
  logic         pwm_a_o, pwm_b_o, zero_o, load_o, cmpa_o, cmpb_o, irq_o, adc_trig_o;

  pwm_gen #(.CNT_W(W)) i_pwm_gen (
    .clk_i(clk), .rst_ni(rst_ni), .updown_i(updown), .sync_upd_i(sync_upd),
    .stall_run_i(stall_run), .irq_sel_i(irq_sel), .trig_sel_i(trig_sel),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .glb_update_i(gupd), .glb_reset_i(greset), .stall_i(stall),
    .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .zero_o(zero_o), .load_o(load_o),
    .cmpa_o(cmpa_o), .cmpb_o(cmpb_o), .irq_o(irq_o), .adc_trig_o(adc_trig_o)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // cycle model of the requirements
  logic [W-1:0] m_cnt = '0;
  bit           m_dir = 1'b1, m_fresh = 1'b0, m_armed = 1'b0, m_pa = 1'b0, m_pb = 1'b0;
  logic [W-1:0] m_act [3] = '{default: '0};
  logic [W-1:0] m_pv  [3] = '{default: '0};
  bit           m_pf  [3] = '{default: 1'b0};

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] model_ev();
    logic [3:0] e;
    e[0] = m_fresh && (m_cnt == '0);
    e[1] = m_fresh && (m_cnt == m_act[0]);
    e[2] = m_fresh && (m_cnt == m_act[1]);
    e[3] = m_fresh && (m_cnt == m_act[2]);
    return e;
  endfunction

  task automatic compare_all();
    logic [3:0] e;
    e = model_ev();
    chk("R2 zero_o", zero_o, e[0]);
    chk("R3 load_o", load_o, e[1]);
    chk("R7 cmpa_o", cmpa_o, e[2]);
    chk("R7 cmpb_o", cmpb_o, e[3]);
    chk("R8 pwm_a_o", pwm_a_o, m_pa);
    chk("R8 pwm_b_o", pwm_b_o, m_pb);
    chk("R11 irq_o", irq_o, |(e & irq_sel));
    chk("R11 adc_trig_o", adc_trig_o, |(e & trig_sel));
  endtask

  task automatic model_step();
    logic [3:0]   e;
    logic [W-1:0] nx;
    bit down, adv, ze, app, nd, any;
    e    = model_ev();
    down = !updown || m_dir;
    adv  = !stall || stall_run || (m_cnt != '0);
    if (!updown) begin
      nx = (m_cnt == '0) ? m_act[0] : W'(m_cnt - 16'd1); nd = 1'b1;
    end else if (m_cnt == '0) begin
      nx = (m_act[0] == '0) ? '0 : 16'd1; nd = 1'b0;
    end else if (!m_dir && m_cnt < m_act[0]) begin
      nx = W'(m_cnt + 16'd1); nd = 1'b0;
    end else begin
      nx = W'(m_cnt - 16'd1); nd = 1'b1;
    end
    ze  = greset || (adv && nx == '0);
    app = ze && (!sync_upd || m_armed);
    any = m_pf[0] || m_pf[1] || m_pf[2];
    if (e[2] && down) m_pa = 1'b0; else if (e[0]) m_pa = 1'b1;
    if (e[3] && down) m_pb = 1'b0; else if (e[0]) m_pb = 1'b1;
    for (int k = 0; k < 3; k++) begin
      if (app && m_pf[k]) m_act[k] = m_pv[k];
      if (wr_en && wr_sel == 2'(k)) begin
        m_pv[k] = wr_data; m_pf[k] = 1'b1;
      end else if (app) begin
        m_pf[k] = 1'b0;
      end
    end
    m_armed = app ? 1'b0 : (m_armed || (gupd && any));
    if (greset) begin
      m_cnt = '0; m_dir = 1'b1; m_fresh = 1'b1;
    end else if (adv) begin
      m_cnt = nx; m_dir = nd; m_fresh = 1'b1;
    end else begin
      m_fresh = 1'b0;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [1:0] sel, int data);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(data);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse_upd();
    gupd = 1'b1; tick(); gupd = 1'b0;
  endtask

  task automatic pulse_reset();
    greset = 1'b1; tick(); greset = 1'b0;
  endtask

  task automatic measure(output int p);
    int guard = 0;
    while (zero_o !== 1'b1 && guard < 200) begin tick(); guard++; end
    p = 0;
    do begin tick(); p++; end while (zero_o !== 1'b1 && p < 200);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p, n, nl;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    chk("R1 pwm_a_o", pwm_a_o, 1'b0);
    chk("R1 pwm_b_o", pwm_b_o, 1'b0);
    chk("R1 zero_o", zero_o, 1'b0);
    compare_all();

    irq_sel = 4'b0001; trig_sel = 4'b0110;
    wr(SEL_PERIOD, 4); wr(SEL_CMPA, 2); wr(SEL_CMPB, 5);
    repeat (3) tick();
    measure(p); measure(p);
    chk_int("R2 sawtooth period", p, 5);

    // R4: immediate update lands at the next zero
    wr(SEL_PERIOD, 6);
    measure(p);
    chk_int("R4 immediate period", p, 7);

    // R12: code 3 writes nothing
    wr(SEL_NONE, 2);
    repeat (4) tick();
    measure(p);
    chk_int("R12 ignored write", p, 7);

    // R5: synchronized update
    sync_upd = 1'b1;
    wr(SEL_PERIOD, 3);
    repeat (20) tick();
    measure(p);
    chk_int("R5 held until update", p, 7);
    pulse_upd();
    measure(p); measure(p);
    chk_int("R5 applied after update", p, 4);
    wr(SEL_PERIOD, 9); wr(SEL_PERIOD, 5);
    pulse_upd();
    measure(p); measure(p);
    chk_int("R5 overwrite", p, 6);

    // R3 and R7: triangle mode
    sync_upd = 1'b0; updown = 1'b1;
    pulse_reset();
    wr(SEL_PERIOD, 4);
    measure(p); measure(p);
    chk_int("R3 triangle period", p, 8);
    n = 0;
    for (int i = 0; i < 8; i++) begin tick(); if (cmpa_o) n++; end
    chk_int("R7 matches per triangle", n, 2);

    // R6: restart mid-period
    updown = 1'b0;
    repeat (3) tick();
    greset = 1'b1; tick(); greset = 1'b0;
    chk("R6 zero after restart", zero_o, 1'b1);

    // R9: stall stops at zero
    stall_run = 1'b0; stall = 1'b1;
    repeat (10) tick();
    n = 0; nl = 0;
    for (int i = 0; i < 10; i++) begin tick(); if (zero_o) n++; if (load_o) nl++; end
    chk_int("R9 no zero while held", n, 0);
    chk_int("R9 no period while held", nl, 0);
    stall = 1'b0;

    // R10: stall ignored when configured to run
    stall_run = 1'b1;
    measure(p);
    stall = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (zero_o) n++; end
    chk_int("R10 zeros during stall", n, 4);
    stall = 1'b0;

    // random phase
    for (int blk = 0; blk < 10; blk++) begin
      updown    = 1'($urandom % 2);
      sync_upd  = 1'($urandom % 2);
      stall_run = 1'($urandom % 2);
      irq_sel   = 4'($urandom % 16);
      trig_sel  = 4'($urandom % 16);
      pulse_reset();
      for (int i = 0; i < 400; i++) begin
        wr_en   = ($urandom % 5) == 0;
        wr_sel  = 2'($urandom % 4);
        wr_data = W'($urandom % 12);
        gupd    = ($urandom % 7) == 0;
        greset  = ($urandom % 150) == 0;
        if (($urandom % 25) == 0) stall = ~stall;
        tick();
      end
      wr_en = 1'b0; gupd = 1'b0; greset = 1'b0; stall = 1'b0;
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule